// File: doc/BRIEF.md
# Parallel Page-Frame Translation Unit

This unit maps virtual word addresses onto physical frames for a small demand-paged store. Each physical frame owns a register that records which virtual page currently lives in that frame, plus a valid flag and a recently-used flag. A lookup compares the requested virtual page number against every frame register at the same time. The index of the matching register is the physical frame number, and the physical address is that index joined to the unchanged in-page offset.

When no register matches, the unit flags a page fault and nominates a frame for the incoming page. An empty frame is preferred. When every frame is occupied, the nomination goes to an occupied frame whose used flag is clear. Software, or a paging engine outside this block, moves the page in and then writes the new page number into the nominated frame through a fill port. Lookups are combinational within the request cycle. Flag and register updates take effect at the next clock edge.

Top module: `frame_xlate`

## Requirements
- R1: After reset every frame is empty, so any request faults and frame 0 is nominated as an empty frame (`vict_free`=1).
- R2: A request whose page number (address bits 16:9) matches a valid frame register gives `rsp_hit`=1, `rsp_fault`=0, and `rsp_paddr` = {frame index (5 bits), address bits 8:0}, all in the same cycle.
- R3: `rsp_hit` and `rsp_fault` are never high together, and both are low whenever `req_valid` is low.
- R4: On a fault with at least one empty frame, `vict_frame` is the lowest-indexed empty frame and `vict_free`=1.
- R5: On a fault with no empty frame, `vict_frame` is the lowest-indexed frame whose used flag is clear, and `vict_free`=0.
- R6: On a fault with every frame valid and used, frame 0 is nominated (`vict_free`=0), and all used flags are cleared at that clock edge.
- R7: A hit sets the used flag of the matching frame at the clock edge that ends the request cycle.
- R8: A fill write (`fill_we`=1) stores `fill_vpn` in frame `fill_frame`, marks the frame valid, and clears its used flag. A request for that page in the next cycle hits that frame. A fill takes precedence over a hit or sweep update to the same frame in the same cycle.
- R9: When several valid registers hold the requested page, the lowest-indexed one provides the hit.
- R10: A cycle with `req_valid` low changes no used flag, even when the address on the request port matches a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 17 | Virtual word address (page number in bits 16:9, offset in bits 8:0) |
| rsp_hit | output | 1 | Request matched a resident page |
| rsp_fault | output | 1 | Request matched no resident page |
| rsp_paddr | output | 14 | Physical address {frame, offset}, meaningful on a hit |
| vict_frame | output | 5 | Frame nominated to receive the missing page, meaningful on a fault |
| vict_free | output | 1 | Nominated frame is empty (1) or holds a page to be evicted (0) |
| fill_we | input | 1 | Fill write strobe |
| fill_frame | input | 5 | Frame index to rewrite |
| fill_vpn | input | 8 | Virtual page number to store |

## Verification
The bench targets the three branches of the nomination. It checks the move from empty frames to stale frames once the store fills up, and it checks the sweep that occurs when every frame is used. If the sweep is missing, the fault after a fully used state nominates the wrong frame. It also checks that a used flag set by a hit moves the next nomination forward, and that an idle cycle whose address happens to match leaves the nomination unchanged. If the design touched the flag while idle, the nomination would move forward. A duplicated page number must resolve to the lower frame, and a priority encoder built in the wrong direction shows up there as the higher index.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int MAX_FRAMES = 64;

  // index of the lowest set bit, 0 when none is set
  function automatic int lowest_set(input logic [MAX_FRAMES-1:0] v);
    int idx;
    logic found;
    idx = 0;
    found = 1'b0;
    for (int i = 0; i < MAX_FRAMES; i++) begin
      if (v[i] && !found) begin
        idx = i;
        found = 1'b1;
      end
    end
    return idx;
  endfunction

  // physical address from frame index and offset
  function automatic logic [MAX_FRAMES-1:0] join_addr(input int frame, input int off, input int off_w);
    logic [MAX_FRAMES-1:0] r;
    r = (MAX_FRAMES'(frame) << off_w) | MAX_FRAMES'(off);
    return r;
  endfunction
endpackage

// File: rtl/xlate_cam.sv
module xlate_cam #(
  parameter int FRAMES = 32,
  parameter int VPN_W  = 8
) (
  input  logic [FRAMES*VPN_W-1:0] vpn_tab,
  input  logic [FRAMES-1:0]       valid_vec,
  input  logic [VPN_W-1:0]        req_vpn,
  output logic [FRAMES-1:0]       match_vec
);
  for (genvar g = 0; g < FRAMES; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] && (vpn_tab[g*VPN_W +: VPN_W] == req_vpn);
  end
endmodule

// File: rtl/xlate_pick.sv
module xlate_pick
  import xlate_pkg::*;
#(
  parameter int FRAMES = 32,
  parameter int FIDX_W = $clog2(FRAMES)
) (
  input  logic [FRAMES-1:0] match_vec,
  input  logic [FRAMES-1:0] valid_vec,
  input  logic [FRAMES-1:0] use_vec,
  output logic              hit_any,
  output logic [FIDX_W-1:0] hit_idx,
  output logic              free_any,
  output logic [FIDX_W-1:0] free_idx,
  output logic              stale_any,
  output logic [FIDX_W-1:0] stale_idx
);
  logic [FRAMES-1:0] free_vec;
  logic [FRAMES-1:0] stale_vec;

  assign free_vec  = ~valid_vec;
  assign stale_vec = valid_vec & ~use_vec;

  assign hit_any   = |match_vec;
  assign free_any  = |free_vec;
  assign stale_any = |stale_vec;

  always_comb begin
    hit_idx   = FIDX_W'(lowest_set(MAX_FRAMES'(match_vec)));
    free_idx  = FIDX_W'(lowest_set(MAX_FRAMES'(free_vec)));
    stale_idx = FIDX_W'(lowest_set(MAX_FRAMES'(stale_vec)));
  end
endmodule

// File: rtl/xlate_regs.sv
module xlate_regs #(
  parameter int FRAMES = 32,
  parameter int VPN_W  = 8,
  parameter int FIDX_W = $clog2(FRAMES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fill_we,
  input  logic [FIDX_W-1:0]       fill_idx,
  input  logic [VPN_W-1:0]        fill_vpn,
  input  logic                    touch_we,
  input  logic [FIDX_W-1:0]       touch_idx,
  input  logic                    sweep,
  output logic [FRAMES*VPN_W-1:0] vpn_tab,
  output logic [FRAMES-1:0]       valid_vec,
  output logic [FRAMES-1:0]       use_vec
);
  for (genvar g = 0; g < FRAMES; g++) begin : g_frame
    logic fill_here;
    logic touch_here;
    assign fill_here  = fill_we  && (fill_idx  == FIDX_W'(g));
    assign touch_here = touch_we && (touch_idx == FIDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[g]                <= 1'b0;
        use_vec[g]                  <= 1'b0;
        vpn_tab[g*VPN_W +: VPN_W]   <= '0;
      end else if (fill_here) begin
        valid_vec[g]                <= 1'b1;
        use_vec[g]                  <= 1'b0;
        vpn_tab[g*VPN_W +: VPN_W]   <= fill_vpn;
      end else if (sweep) begin
        use_vec[g]                  <= 1'b0;
      end else if (touch_here) begin
        use_vec[g]                  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/frame_xlate.sv
module frame_xlate #(
  parameter int FRAMES = 32,
  parameter int VPN_W  = 8,
  parameter int OFF_W  = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [VPN_W+OFF_W-1:0]       req_vaddr,
  output logic                         rsp_hit,
  output logic                         rsp_fault,
  output logic [$clog2(FRAMES)+OFF_W-1:0] rsp_paddr,
  output logic [$clog2(FRAMES)-1:0]    vict_frame,
  output logic                         vict_free,
  input  logic                         fill_we,
  input  logic [$clog2(FRAMES)-1:0]    fill_frame,
  input  logic [VPN_W-1:0]             fill_vpn
);
  localparam int FIDX_W = $clog2(FRAMES);

  logic [VPN_W-1:0]        req_vpn;
  logic [OFF_W-1:0]        req_off;
  logic [FRAMES*VPN_W-1:0] vpn_tab;
  logic [FRAMES-1:0]       valid_vec;
  logic [FRAMES-1:0]       use_vec;
  logic [FRAMES-1:0]       match_vec;
  logic                    hit_any, free_any, stale_any;
  logic [FIDX_W-1:0]       hit_idx, free_idx, stale_idx;

  // named internal events
  logic ev_touch;
  logic ev_sweep;

  assign req_vpn = req_vaddr[OFF_W +: VPN_W];
  assign req_off = req_vaddr[OFF_W-1:0];

  xlate_cam #(.FRAMES(FRAMES), .VPN_W(VPN_W)) cam_i (
    .vpn_tab   (vpn_tab),
    .valid_vec (valid_vec),
    .req_vpn   (req_vpn),
    .match_vec (match_vec)
  );

  xlate_pick #(.FRAMES(FRAMES), .FIDX_W(FIDX_W)) pick_i (
    .match_vec (match_vec),
    .valid_vec (valid_vec),
    .use_vec   (use_vec),
    .hit_any   (hit_any),
    .hit_idx   (hit_idx),
    .free_any  (free_any),
    .free_idx  (free_idx),
    .stale_any (stale_any),
    .stale_idx (stale_idx)
  );

  assign rsp_hit   = req_valid &&  hit_any;
  assign rsp_fault = req_valid && !hit_any;
  assign rsp_paddr = {hit_idx, req_off};

  assign vict_free  = free_any;
  assign vict_frame = free_any ? free_idx : (stale_any ? stale_idx : '0);

  assign ev_touch = rsp_hit;
  assign ev_sweep = rsp_fault && !free_any && !stale_any;

  xlate_regs #(.FRAMES(FRAMES), .VPN_W(VPN_W), .FIDX_W(FIDX_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_we   (fill_we),
    .fill_idx  (fill_frame),
    .fill_vpn  (fill_vpn),
    .touch_we  (ev_touch),
    .touch_idx (hit_idx),
    .sweep     (ev_sweep),
    .vpn_tab   (vpn_tab),
    .valid_vec (valid_vec),
    .use_vec   (use_vec)
  );
endmodule

// File: rtl/frame_xlate_chk.sv
module frame_xlate_chk #(
  parameter int FRAMES = 32,
  parameter int OFF_W  = 9,
  parameter int FIDX_W = $clog2(FRAMES)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    rsp_hit,
  input logic                    rsp_fault,
  input logic [FIDX_W+OFF_W-1:0] rsp_paddr,
  input logic [FIDX_W-1:0]       vict_frame,
  input logic                    vict_free,
  input logic                    fill_we,
  input logic [FIDX_W-1:0]       fill_frame,
  input logic [FRAMES-1:0]       valid_vec,
  input logic [FRAMES-1:0]       use_vec
);
  AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!rsp_hit && !rsp_fault)); // R3
  AST_HIT_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> valid_vec[rsp_paddr[OFF_W +: FIDX_W]]); // R2
  AST_FREE_IS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault && vict_free) |-> !valid_vec[vict_frame]); // R4
  AST_EVICT_IS_STALE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault && !vict_free && !(&use_vec)) |-> !use_vec[vict_frame]); // R5
  AST_SWEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault && (&use_vec)) |=> (use_vec == '0)); // R6
  AST_HIT_MARKS_USE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && !(fill_we && fill_frame == rsp_paddr[OFF_W +: FIDX_W]))
      |=> use_vec[$past(rsp_paddr[OFF_W +: FIDX_W])]); // R7
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> (valid_vec[$past(fill_frame)] && !use_vec[$past(fill_frame)])); // R8
endmodule

bind frame_xlate frame_xlate_chk #(.FRAMES(FRAMES), .OFF_W(OFF_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .rsp_hit    (rsp_hit),
  .rsp_fault  (rsp_fault),
  .rsp_paddr  (rsp_paddr),
  .vict_frame (vict_frame),
  .vict_free  (vict_free),
  .fill_we    (fill_we),
  .fill_frame (fill_frame),
  .valid_vec  (valid_vec),
  .use_vec    (use_vec)
);

// File: tb/frame_xlate_tb_top.sv
module frame_xlate_tb_top;
  localparam int CLK_P = 10;
  localparam int NF = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [16:0] req_vaddr = '0;
  logic        rsp_hit, rsp_fault, vict_free;
  logic [13:0] rsp_paddr;
  logic [4:0]  vict_frame;
  logic        fill_we = 1'b0;
  logic [4:0]  fill_frame = '0;
  logic [7:0]  fill_vpn = '0;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  int m_valid [NF];
  int m_use   [NF];
  int m_vpn   [NF];

  always #(CLK_P/2) clk = ~clk;

  frame_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .vict_frame(vict_frame), .vict_free(vict_free),
    .fill_we(fill_we), .fill_frame(fill_frame), .fill_vpn(fill_vpn)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input int vpn, input int off,
                      input bit fw, input int ff, input int fv, input string tag);
    int h, vic, vfree, nused;
    bit allv, allu;
    @(negedge clk);
    req_valid = v; req_vaddr = {vpn[7:0], off[8:0]};
    fill_we = fw; fill_frame = ff[4:0]; fill_vpn = fv[7:0];
    #2;
    h = -1; vic = -1; vfree = 0; allv = 1; allu = 1;
    foreach (m_valid[i]) if (m_valid[i] != 0 && m_vpn[i] == vpn && h < 0) h = i;
    foreach (m_valid[i]) if (m_valid[i] == 0 && vic < 0) begin vic = i; vfree = 1; end
    if (vic < 0) foreach (m_use[i]) if (m_use[i] == 0 && vic < 0) vic = i;
    if (vic < 0) vic = 0;
    foreach (m_valid[i]) begin
      if (m_valid[i] == 0) allv = 0;
      if (m_use[i] == 0) allu = 0;
    end
    chk(tag, "hit", int'(rsp_hit), (v && h >= 0) ? 1 : 0);
    chk(tag, "fault", int'(rsp_fault), (v && h < 0) ? 1 : 0);
    if (v && h >= 0) chk(tag, "paddr", int'(rsp_paddr), h * 512 + off);
    if (v && h < 0) begin
      chk(tag, "victim", int'(vict_frame), vic);
      chk(tag, "victim_free", int'(vict_free), vfree);
    end
    @(posedge clk);
    #1;
    if (v && h >= 0) m_use[h] = 1;
    if (v && h < 0 && allv && allu) foreach (m_use[i]) m_use[i] = 0;
    if (fw) begin m_valid[ff] = 1; m_use[ff] = 0; m_vpn[ff] = fv; end
  endtask

  task automatic look(input int vpn, input string tag);
    step(1'b1, vpn, (vpn * 37) % 512, 1'b0, 0, 0, tag);
  endtask

  task automatic fill(input int ff, input int fv, input string tag);
    step(1'b0, 0, 0, 1'b1, ff, fv, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    foreach (m_valid[i]) begin m_valid[i] = 0; m_use[i] = 0; m_vpn[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: empty after reset
    step(1'b0, 0, 0, 1'b0, 0, 0, "R1");
    look(0, "R1");
    look(191, "R1");
    // R8: fill then hit next cycle
    for (int i = 0; i < 4; i++) fill(i, 100 + i, "R8");
    for (int i = 0; i < 4; i++) look(100 + i, "R2");
    step(1'b1, 101, 0, 1'b0, 0, 0, "R2");
    step(1'b1, 101, 511, 1'b0, 0, 0, "R2");
    // R4: lowest empty frame nominated
    look(7, "R4");
    fill(6, 50, "R4");
    look(8, "R4");
    // fill all frames
    for (int i = 0; i < NF; i++) fill(i, 10 + i, "R8");
    // R5: stale frames after all valid
    look(200, "R5");
    for (int i = 0; i < 3; i++) look(10 + i, "R7");
    look(201, "R7");
    look(13, "R7");
    look(202, "R5");
    // R6: every frame used then fault
    for (int i = 0; i < NF; i++) look(10 + i, "R7");
    look(203, "R6");
    look(204, "R6");
    look(10, "R6");
    look(205, "R6");
    // R10: idle request matching frame 5 must not mark it
    for (int i = 1; i < 5; i++) look(10 + i, "R10");
    step(1'b0, 15, 3, 1'b0, 0, 0, "R10");
    step(1'b0, 15, 4, 1'b0, 0, 0, "R10");
    look(206, "R10");
    // R9: duplicated page resolves to lower frame
    fill(20, 17, "R9");
    look(17, "R9");
    fill(3, 30, "R9");
    look(30, "R9");
    // R8: fill overrides same-cycle hit on that frame
    step(1'b1, 30, 1, 1'b1, 3, 77, "R8");
    look(77, "R8");
    look(30, "R8");
    // R3: mixed traffic
    for (int n = 0; n < 600; n++) begin
      int r = int'($urandom_range(0, 9));
      int vp = int'($urandom_range(0, 47));
      if (r < 2) step(1'b0, vp, int'($urandom_range(0, 511)), 1'b1,
                      int'($urandom_range(0, 31)), vp, "R3");
      else if (r < 3) step(1'b0, vp, 0, 1'b0, 0, 0, "R3");
      else step(1'b1, vp, int'($urandom_range(0, 511)), 1'b0, 0, 0, "R3");
    end
    // R1: reset empties everything again
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; fill_we = 1'b0;
    @(posedge clk); #1;
    foreach (m_valid[i]) begin m_valid[i] = 0; m_use[i] = 0; end
    @(negedge clk); rst_n = 1'b1;
    look(30, "R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule